// File: doc/BRIEF.md
# Two-Stage Multiply-Accumulate Unit

This block is a multiply-accumulate datapath with its own adder. It does not use the main ALU, so a multiply never holds up the execute stage. Every cycle it can accept one operation. The operation carries a 32-bit multiplicand, a 16-bit slice of the multiplier, a 32-bit accumulator, an accumulate enable, a pass selector and a destination tag.

The first stage multiplies the operand by the 16-bit slice in an array. It reduces the partial products to a sum vector and a carry vector in carry-save form and registers them. The second stage merges sum, carry and an addend in one 3:2 compression, then resolves them with a single carry-propagate add into the registered result. For a low pass the addend is the accumulator, or zero when accumulate is off. For a high pass the array output is shifted left by 16, and the addend is the previous result. A full 32x32 multiply-accumulate is therefore a low pass on bits 15:0 of the multiplier followed at once by a high pass on bits 31:16. Only the low 32 bits of each result are kept. The second stage shares no resource with the memory path, so it never waits on arbitration.

Top module: `mac2s_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0 and out_result is 0.
- R2: An operation accepted with in_valid=1 appears with out_valid=1 exactly two clock edges later, carrying the same tag, provided flush is low on both of those edges.
- R3: A low pass (in_hi=0) with in_acc_en=1 yields (in_a * in_b + in_acc) mod 2^32, with in_b taken as unsigned.
- R4: A low pass with in_acc_en=0 yields (in_a * in_b) mod 2^32, whatever value in_acc holds.
- R5: A high pass (in_hi=1) yields ((in_a * in_b) << 16) + R mod 2^32. R is the result produced on the edge just before its own result. in_acc and in_acc_en have no effect on it.
- R6: A low pass on multiplier bits 15:0 followed on the next cycle by a high pass on bits 31:16, with the same in_a, gives (in_a * B + in_acc) mod 2^32 for the full 32-bit multiplier B.
- R7: Operations issued on consecutive cycles produce results on consecutive cycles, in issue order, with no stall.
- R8: flush=1 on an edge discards the operation in each stage. The operation presented on that edge and the one in the first stage never produce out_valid=1.
- R9: While out_valid is 0, out_result keeps its previous value.
- R10: The registered sum and carry vectors of the first stage add, mod 2^32, to the slice product, which is shifted by 16 for a high pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous pipeline flush, clears both stage valids |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | 32 | Multiplicand |
| in_b | input | 16 | Multiplier slice (unsigned) |
| in_acc | input | 32 | Accumulator value for a low pass |
| in_acc_en | input | 1 | 1 adds in_acc, 0 adds zero (low pass only) |
| in_hi | input | 1 | 0 low pass, 1 high pass (shift 16, chain previous result) |
| in_tag | input | 4 | Destination tag |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Result, low 32 bits |
| out_tag | output | 4 | Tag of the result |

## Verification
Walking-one multiplier slices with corner multiplicands (zero, one, all ones, sign bit, alternating bits) exercise each row of the partial-product array on its own. All-ones slices exercise the longest carry chains. A stream of pseudo-random low passes with accumulate on and off shows whether the accumulator is added, or correctly ignored, while issue never pauses. Paired low and high passes are compared against a full 32x32 product plus accumulator computed in the bench, which exposes a wrong shift or a wrong chained addend. A flush issued among valid operations separates dropped work from results that still complete.

// File: rtl/mac2s_pkg.sv
package mac2s_pkg;
  typedef enum logic {
    PASS_LO = 1'b0,
    PASS_HI = 1'b1
  } pass_e;
endpackage

// File: rtl/mac2s_csa.sv
module mac2s_csa #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  logic [W-1:0] maj;
  always_comb begin
    s   = x ^ y ^ z;
    maj = (x & y) | (x & z) | (y & z);
    c   = {maj[W-2:0], 1'b0};
  end
endmodule

// File: rtl/mac2s_ppgen.sv
module mac2s_ppgen #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 16
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [SLICE_W-1:0] b,
  input  mac2s_pkg::pass_e   pass,
  output logic [DATA_W-1:0]  sum,
  output logic [DATA_W-1:0]  carry
);
  logic [DATA_W-1:0] pp    [SLICE_W];
  logic [DATA_W-1:0] s_ch  [SLICE_W];
  logic [DATA_W-1:0] c_ch  [SLICE_W];

  for (genvar i = 0; i < SLICE_W; i++) begin : g_row
    assign pp[i] = ({DATA_W{b[i]}} & a) << i;
  end

  assign s_ch[0] = '0;
  assign c_ch[0] = '0;
  assign s_ch[1] = pp[0];
  assign c_ch[1] = pp[1];

  for (genvar i = 2; i < SLICE_W; i++) begin : g_chain
    mac2s_csa #(.W(DATA_W)) u_csa (
      .x (s_ch[i-1]),
      .y (c_ch[i-1]),
      .z (pp[i]),
      .s (s_ch[i]),
      .c (c_ch[i])
    );
  end

  always_comb begin
    if (pass == mac2s_pkg::PASS_HI) begin
      sum   = s_ch[SLICE_W-1] << SLICE_W;
      carry = c_ch[SLICE_W-1] << SLICE_W;
    end else begin
      sum   = s_ch[SLICE_W-1];
      carry = c_ch[SLICE_W-1];
    end
  end
endmodule

// File: rtl/mac2s_final.sv
module mac2s_final #(
  parameter int W = 32
) (
  input  logic [W-1:0] sum,
  input  logic [W-1:0] carry,
  input  logic [W-1:0] addend,
  output logic [W-1:0] result
);
  logic [W-1:0] cs_s;
  logic [W-1:0] cs_c;

  mac2s_csa #(.W(W)) u_merge (
    .x (sum),
    .y (carry),
    .z (addend),
    .s (cs_s),
    .c (cs_c)
  );

  always_comb result = cs_s + cs_c;
endmodule

// File: rtl/mac2s_unit.sv
module mac2s_unit #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 16,
  parameter int TAG_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_a,
  input  logic [SLICE_W-1:0] in_b,
  input  logic [DATA_W-1:0]  in_acc,
  input  logic               in_acc_en,
  input  logic               in_hi,
  input  logic [TAG_W-1:0]   in_tag,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_result,
  output logic [TAG_W-1:0]   out_tag
);
  import mac2s_pkg::*;

  localparam int PAD_W = DATA_W - SLICE_W;

  pass_e             in_pass;
  logic [DATA_W-1:0] pp_sum;
  logic [DATA_W-1:0] pp_carry;

  logic              s1_valid;
  pass_e             s1_pass;
  logic [DATA_W-1:0] s1_sum;
  logic [DATA_W-1:0] s1_carry;
  logic [DATA_W-1:0] s1_acc;
  logic [TAG_W-1:0]  s1_tag;

  logic [DATA_W-1:0] s2_addend;
  logic [DATA_W-1:0] s2_result;

  assign in_pass = in_hi ? PASS_HI : PASS_LO;

  // Stage 1: 16xN array into carry-save pair
  mac2s_ppgen #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_ppgen (
    .a     (in_a),
    .b     (in_b),
    .pass  (in_pass),
    .sum   (pp_sum),
    .carry (pp_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_pass  <= PASS_LO;
      s1_sum   <= '0;
      s1_carry <= '0;
      s1_acc   <= '0;
      s1_tag   <= '0;
    end else begin
      s1_valid <= in_valid && !flush;
      if (in_valid) begin
        s1_pass  <= in_pass;
        s1_sum   <= pp_sum;
        s1_carry <= pp_carry;
        s1_acc   <= in_acc_en ? in_acc : '0;
        s1_tag   <= in_tag;
      end
    end
  end

  // Stage 2: dedicated final adder, chained addend for high pass
  assign s2_addend = (s1_pass == PASS_HI) ? out_result : s1_acc;

  mac2s_final #(.W(DATA_W)) u_final (
    .sum    (s1_sum),
    .carry  (s1_carry),
    .addend (s2_addend),
    .result (s2_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_tag    <= '0;
    end else begin
      out_valid <= s1_valid && !flush;
      if (s1_valid && !flush) begin
        out_result <= s2_result;
        out_tag    <= s1_tag;
      end
    end
  end

  // Reference product for the carry-save pair check
  logic [DATA_W-1:0] ref_prod;
  always_comb begin
    ref_prod = in_a * {{PAD_W{1'b0}}, in_b};
    if (in_hi) ref_prod = ref_prod << SLICE_W;
  end

  // R10
  csa_pair_chk: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (DATA_W'(s1_sum + s1_carry) == $past(ref_prod)));

  // R2
  lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flush) ##1 !flush |=> out_valid);

  // R2
  tag_carry_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_tag == $past(in_tag, 2)));

  // R8
  flush_kill_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> !out_valid);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_result));
endmodule

// File: tb/mac2s_unit_tb.sv
`timescale 1ns/1ps
module mac2s_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic [31:0] in_acc = '0;
  logic        in_acc_en = 1'b0;
  logic        in_hi = 1'b0;
  logic [3:0]  in_tag = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [3:0]  out_tag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mac2s_unit u_dut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc), .in_acc_en(in_acc_en),
    .in_hi(in_hi), .in_tag(in_tag), .out_valid(out_valid),
    .out_result(out_result), .out_tag(out_tag)
  );

  // bench model state
  bit          m_v = 0, m_hi = 0, m_ov = 0;
  logic [31:0] m_term = 0, m_add = 0, m_ovval = 0;
  logic [3:0]  m_tag = 0;
  string       m_lbl = "R1";
  bit          e_v = 0, e_ov = 0;
  logic [31:0] e_res = 0, e_ovval = 0;
  logic [3:0]  e_tag = 0;
  string       e_lbl = "R1";
  logic [3:0]  tag_ctr = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic step(input bit v, input logic [31:0] a, input logic [15:0] b,
                      input logic [31:0] acc, input bit en, input bit hi,
                      input bit fl, input string lbl,
                      input bit ov, input logic [31:0] ovval);
    logic [31:0] p;
    @(negedge clk);
    chk(out_valid == e_v, e_lbl, "out_valid", {31'b0, out_valid}, {31'b0, e_v});
    if (e_v) begin
      chk(out_tag == e_tag, "R2", "out_tag", {28'b0, out_tag}, {28'b0, e_tag});
      chk(out_result == e_res, e_lbl, "out_result", out_result, e_res);
      if (e_ov) chk(out_result == e_ovval, "R6", "full product", out_result, e_ovval);
    end else begin
      chk(out_result == e_res, "R9", "held result", out_result, e_res);
    end
    in_valid = v; in_a = a; in_b = b; in_acc = acc; in_acc_en = en;
    in_hi = hi; flush = fl; in_tag = tag_ctr;
    // model: stage 2 then stage 1
    if (m_v && !fl) begin
      e_v = 1; e_tag = m_tag; e_lbl = m_lbl; e_ov = m_ov; e_ovval = m_ovval;
      e_res = m_hi ? (m_term + e_res) : (m_term + m_add);
    end else begin
      e_v = 0; e_ov = 0; e_lbl = fl ? "R8" : "R9";
    end
    p = a * {16'b0, b};
    m_v = v && !fl; m_hi = hi; m_tag = tag_ctr; m_lbl = lbl;
    m_term = hi ? (p << 16) : p;
    m_add = en ? acc : 32'h0;
    m_ov = ov; m_ovval = ovval;
    if (v) tag_ctr = tag_ctr + 4'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "R9", 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] corner [5];
    logic [31:0] a, acc, bfull;
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h8000_0000;
    corner[4] = 32'hA5A5_5A5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid in reset", {31'b0, out_valid}, 32'd0);
    chk(out_result == 32'd0, "R1", "out_result in reset", out_result, 32'd0);
    rst = 1'b0;
    idle(2);

    // R3/R4: corner multiplicands x walking-one and boundary slices
    for (int ci = 0; ci < 5; ci++) begin
      for (int k = 0; k < 18; k++) begin
        logic [15:0] bs;
        bs = (k < 16) ? (16'h1 << k) : ((k == 16) ? 16'h0000 : 16'hFFFF);
        step(1, corner[ci], bs, 32'h0F0F_F0F0, k[0], 0, 0,
             k[0] ? "R3" : "R4", 0, 0);
      end
    end
    idle(3);

    // R7: back-to-back random stream, accumulate on and off (R3/R4)
    for (int i = 0; i < 600; i++) begin
      seed = nxt(seed); a = seed;
      seed = nxt(seed); acc = seed;
      step(1, a, seed[15:0], acc, seed[20], 0, 0, "R7", 0, 0);
    end
    idle(3);

    // R5: isolated high pass after a known low pass, acc ignored
    for (int i = 0; i < 50; i++) begin
      seed = nxt(seed); a = seed;
      step(1, a, seed[31:16], 32'h1111_2222, 1, 0, 0, "R3", 0, 0);
      seed = nxt(seed);
      step(1, seed, seed[15:0], 32'hDEAD_BEEF, seed[3], 1, 0, "R5", 0, 0);
      idle(2);
    end

    // R6: full 32x32 in streamed lo/hi pairs
    for (int i = 0; i < 400; i++) begin
      seed = nxt(seed); a = seed;
      seed = nxt(seed); bfull = seed;
      seed = nxt(seed); acc = (i % 7 == 0) ? 32'h0 : seed;
      if (i < 4) begin
        a = corner[i + 1]; bfull = 32'hFFFF_FFFF;
      end
      step(1, a, bfull[15:0], acc, 1, 0, 0, "R3", 0, 0);
      step(1, a, bfull[31:16], 32'h0, 0, 1, 0, "R5", 1, a * bfull + acc);
    end
    idle(3);

    // R8: flush with ops in both stages and one presented
    for (int r = 0; r < 20; r++) begin
      seed = nxt(seed);
      step(1, seed, seed[15:0], 32'h5, 1, 0, 0, "R3", 0, 0);
      step(1, seed, seed[31:16], 32'h7, 1, 0, 0, "R3", 0, 0);
      step(1, seed, 16'h3, 32'h9, 1, 0, 1, "R8", 0, 0);
      step(1, ~seed, 16'h5, 32'h1, 1, 0, (r % 2 == 1), "R8", 0, 0);
      idle(3);
    end

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule